// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Controller

This block is the hazard control logic for an in-order pipeline with five stages: fetch, decode, execute, memory and writeback. The pipeline runs an eight-opcode register ISA. The block looks at the instruction words held in four pipeline registers plus one retired-result register. From those it produces, in the same cycle, the control that keeps execution correct. That control covers three things:

- **Forwarding selects** for the two ALU operands of the instruction in execute.
- **Load-use hold:** when a load in execute feeds the instruction in decode, fetch and decode are held and a noop is sent into execute.
- **Squash:** when a branch resolves taken in the memory stage, the three younger instructions are squashed.

Branches are predicted not taken, so fetch continues sequentially until a branch resolves. The datapath, register file and memories sit outside the block. Each stage word carries an opcode and three register fields. An empty stage simply holds a noop.

The block is purely combinational. It has no valid/ready interface, because no data stream passes through it. Every pin is a plain control or status level.

Top module: `hazard_ctrl`

## Requirements
- R1: Each stage word is `{op, ra, rb, rd}`, with op in the top 3 bits, then ra, rb and rd of REG_W bits each (rd lowest). Opcode values are add=0, nor=1, lw=2, sw=3, beq=4, jalr=5, halt=6, noop=7. Only add and nor (writing rd) and lw (writing rb) produce a register value. All other opcodes produce none.
- R2: Operand use per opcode is as follows. add, nor, sw and beq read both ra and rb. lw and jalr read ra only. halt and noop read nothing.
- R3: `fwd_a` selects the source for operand ra of the execute instruction. The encoding is 0 = register file, 1 = memory-stage word, 2 = writeback-stage word, 3 = retired word. A nonzero select names a stage whose producer destination equals the execute ra, and it is nonzero only when the execute opcode reads ra.
- R4: `fwd_b` follows the same rule for operand rb. It is 0 whenever the execute opcode does not read rb.
- R5: When several stages produce the needed register, the nearest one wins. The memory stage beats writeback, and writeback beats retired.
- R6: A load-use hazard exists when the execute word is lw and the decode opcode reads a field equal to that lw's rb. While no squash is active, such a hazard raises `hold_front` and `bubble_exe` together in the same cycle. Without such a hazard, both stay 0.
- R7: A register match on a field the decode opcode does not read never causes a hold. This covers, for example, rb under lw or jalr, and any field under halt or noop.
- R8: `flush_dec`, `flush_exe` and `flush_mem` are all 1 exactly when the memory word is beq and `br_taken` is 1. `br_taken` has no effect for any other memory opcode.
- R9: A squash takes priority over a load-use hazard raised in the same cycle. In that case `hold_front` and `bubble_exe` are 0.
- R10: With every stage holding a noop and `br_taken` low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_word | input | 3+3*REG_W | Instruction in the decode pipeline register |
| exe_word | input | 3+3*REG_W | Instruction in the execute pipeline register |
| mem_word | input | 3+3*REG_W | Instruction in the memory pipeline register |
| wb_word | input | 3+3*REG_W | Instruction in the writeback pipeline register |
| ret_word | input | 3+3*REG_W | Instruction whose result has just been written (retired) |
| br_taken | input | 1 | Branch comparison result from the memory stage |
| fwd_a | output | 2 | Source select for operand ra in execute |
| fwd_b | output | 2 | Source select for operand rb in execute |
| hold_front | output | 1 | Hold the PC and the decode register |
| bubble_exe | output | 1 | Load a noop into the execute register |
| flush_dec | output | 1 | Replace the next decode-register contents with a noop |
| flush_exe | output | 1 | Replace the next execute-register contents with a noop |
| flush_mem | output | 1 | Replace the next memory-register contents with a noop |

## Verification
A load-use hazard and a taken-branch squash can occur in the same cycle. The bench provokes this by placing a lw in execute, a dependent reader in decode and a beq in memory, then sweeping `br_taken`. It expects the flush lines high and the hold and bubble low whenever the branch is taken. Forwarding priority is judged by sweeping the producer opcode and destination in all three older stages together. The expected select is computed as the nearest matching producer.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
  localparam int OP_W  = 3;
  localparam int N_FWD = 3;
  localparam int SEL_W = $clog2(N_FWD + 1);

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 3'd0,
    OP_NOR  = 3'd1,
    OP_LW   = 3'd2,
    OP_SW   = 3'd3,
    OP_BEQ  = 3'd4,
    OP_JALR = 3'd5,
    OP_HALT = 3'd6,
    OP_NOOP = 3'd7
  } op_e;

  function automatic logic op_reads_a(input logic [OP_W-1:0] op);
    return op inside {OP_ADD, OP_NOR, OP_LW, OP_SW, OP_BEQ, OP_JALR};
  endfunction

  function automatic logic op_reads_b(input logic [OP_W-1:0] op);
    return op inside {OP_ADD, OP_NOR, OP_SW, OP_BEQ};
  endfunction

  function automatic logic op_writes(input logic [OP_W-1:0] op);
    return op inside {OP_ADD, OP_NOR, OP_LW};
  endfunction
endpackage

// File: rtl/hzc_prod_dec.sv
module hzc_prod_dec
  import hzc_pkg::*;
#(
  parameter int REG_W = 3,
  localparam int WORD_W = OP_W + 3 * REG_W
) (
  input  logic [WORD_W-1:0] word,
  output logic              wr,
  output logic [REG_W-1:0]  dest
);
  logic [OP_W-1:0]  op;
  logic [REG_W-1:0] f_rb, f_rd;

  assign op   = word[WORD_W-1 -: OP_W];
  assign f_rb = word[REG_W +: REG_W];
  assign f_rd = word[0 +: REG_W];

  // lw targets its rb field, add/nor target rd (R1)
  assign wr   = op_writes(op);
  assign dest = (op == OP_LW) ? f_rb : f_rd;
endmodule

// File: rtl/hzc_fwd_sel.sv
module hzc_fwd_sel
  import hzc_pkg::*;
#(
  parameter int REG_W = 3
) (
  input  logic                         need,
  input  logic [REG_W-1:0]             src,
  input  logic [N_FWD-1:0]             wr,
  input  logic [N_FWD-1:0][REG_W-1:0]  dst,
  output logic [SEL_W-1:0]             sel
);
  // Scan oldest to nearest so the nearest match is written last (R5)
  always_comb begin
    sel = '0;
    for (int i = N_FWD - 1; i >= 0; i--) begin
      if (need && wr[i] && (dst[i] == src)) sel = SEL_W'(i + 1);
    end
  end

  always_comb begin
    if (sel != '0) begin
      assert_fwd_needed_R3: assert (need)
        else $error("select raised for an operand that is not read");
      for (int j = 0; j < N_FWD; j++) begin
        if (j < int'(sel) - 1) begin
          assert_nearest_wins_R5: assert (!(wr[j] && dst[j] == src))
            else $error("a nearer producer was skipped");
        end
      end
    end
  end
endmodule

// File: rtl/hzc_load_use.sv
module hzc_load_use
  import hzc_pkg::*;
#(
  parameter int REG_W = 3
) (
  input  logic [OP_W-1:0]  dec_op,
  input  logic [REG_W-1:0] dec_ra,
  input  logic [REG_W-1:0] dec_rb,
  input  logic [OP_W-1:0]  exe_op,
  input  logic [REG_W-1:0] exe_dest,
  output logic             hazard
);
  logic hit_a, hit_b;

  // Only fields the decode opcode actually reads count (R7)
  assign hit_a  = op_reads_a(dec_op) && (dec_ra == exe_dest);
  assign hit_b  = op_reads_b(dec_op) && (dec_rb == exe_dest);
  assign hazard = (exe_op == OP_LW) && (hit_a || hit_b);
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hzc_pkg::*;
#(
  parameter int REG_W = 3,
  localparam int WORD_W = OP_W + 3 * REG_W
) (
  input  logic [WORD_W-1:0] dec_word,
  input  logic [WORD_W-1:0] exe_word,
  input  logic [WORD_W-1:0] mem_word,
  input  logic [WORD_W-1:0] wb_word,
  input  logic [WORD_W-1:0] ret_word,
  input  logic              br_taken,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b,
  output logic              hold_front,
  output logic              bubble_exe,
  output logic              flush_dec,
  output logic              flush_exe,
  output logic              flush_mem
);
  localparam int RA_LSB = 2 * REG_W;
  localparam int RB_LSB = REG_W;

  logic [OP_W-1:0]  dec_op, exe_op, mem_op;
  logic [REG_W-1:0] exe_ra, exe_rb;

  assign dec_op = dec_word[WORD_W-1 -: OP_W];
  assign exe_op = exe_word[WORD_W-1 -: OP_W];
  assign mem_op = mem_word[WORD_W-1 -: OP_W];
  assign exe_ra = exe_word[RA_LSB +: REG_W];
  assign exe_rb = exe_word[RB_LSB +: REG_W];

  // Producer decode for the execute stage (load-use) and the three forward sources
  logic [N_FWD-1:0][WORD_W-1:0] src_word;
  logic [N_FWD-1:0]             src_wr;
  logic [N_FWD-1:0][REG_W-1:0]  src_dst;
  logic                         exe_wr;
  logic [REG_W-1:0]             exe_dst;

  assign src_word[0] = mem_word;
  assign src_word[1] = wb_word;
  assign src_word[2] = ret_word;

  hzc_prod_dec #(.REG_W(REG_W)) u_exe_dec (
    .word(exe_word), .wr(exe_wr), .dest(exe_dst)
  );

  generate
    for (genvar s = 0; s < N_FWD; s++) begin : g_src
      hzc_prod_dec #(.REG_W(REG_W)) u_dec (
        .word(src_word[s]), .wr(src_wr[s]), .dest(src_dst[s])
      );
    end
  endgenerate

  // One select unit per ALU operand
  logic [1:0]             opnd_need;
  logic [1:0][REG_W-1:0]  opnd_reg;
  logic [1:0][SEL_W-1:0]  opnd_sel;

  assign opnd_need[0] = op_reads_a(exe_op);
  assign opnd_need[1] = op_reads_b(exe_op);
  assign opnd_reg[0]  = exe_ra;
  assign opnd_reg[1]  = exe_rb;

  generate
    for (genvar k = 0; k < 2; k++) begin : g_opnd
      hzc_fwd_sel #(.REG_W(REG_W)) u_sel (
        .need(opnd_need[k]), .src(opnd_reg[k]),
        .wr(src_wr), .dst(src_dst), .sel(opnd_sel[k])
      );
    end
  endgenerate

  assign fwd_a = opnd_sel[0];
  assign fwd_b = opnd_sel[1];

  // Load-use detection and squash
  logic lu_hazard, squash;

  hzc_load_use #(.REG_W(REG_W)) u_lu (
    .dec_op(dec_op),
    .dec_ra(dec_word[RA_LSB +: REG_W]),
    .dec_rb(dec_word[RB_LSB +: REG_W]),
    .exe_op(exe_op),
    .exe_dest(exe_dst),
    .hazard(lu_hazard)
  );

  assign squash     = (mem_op == OP_BEQ) && br_taken;
  assign hold_front = lu_hazard && !squash;
  assign bubble_exe = hold_front;
  assign flush_dec  = squash;
  assign flush_exe  = squash;
  assign flush_mem  = squash;

  always_comb begin
    assert_squash_wins_R9: assert (!(flush_mem && hold_front))
      else $error("hold raised during a squash");
    if (hold_front) begin
      assert_hold_needs_load_R6: assert (exe_wr && exe_op == OP_LW)
        else $error("hold without a load in execute");
    end
    if (!br_taken) begin
      assert_no_flush_untaken_R8: assert (!(flush_dec || flush_exe || flush_mem))
        else $error("flush without a taken branch");
    end
  end
endmodule

// File: tb/hazard_ctrl_tb.sv
module hazard_ctrl_tb;
  localparam int REG_W = 3;
  localparam int WW = 3 + 3 * REG_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [WW-1:0] dec_word, exe_word, mem_word, wb_word, ret_word;
  logic br_taken;
  logic [1:0] fwd_a, fwd_b;
  logic hold_front, bubble_exe, flush_dec, flush_exe, flush_mem;

  hazard_ctrl #(.REG_W(REG_W)) u_dut (
    .dec_word(dec_word), .exe_word(exe_word), .mem_word(mem_word),
    .wb_word(wb_word), .ret_word(ret_word), .br_taken(br_taken),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .hold_front(hold_front),
    .bubble_exe(bubble_exe), .flush_dec(flush_dec),
    .flush_exe(flush_exe), .flush_mem(flush_mem)
  );

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  localparam logic [2:0] NOOP = 3'd7;
  localparam logic [WW-1:0] NOP_W = {NOOP, 9'd0};

  function automatic bit reads_a(input logic [2:0] op);
    return op <= 3'd5;
  endfunction
  function automatic bit reads_b(input logic [2:0] op);
    return op == 3'd0 || op == 3'd1 || op == 3'd3 || op == 3'd4;
  endfunction
  function automatic bit writes(input logic [2:0] op);
    return op <= 3'd2;
  endfunction
  // Producer word {op,0,r,3-r}: lw writes rb=r, add/nor write rd=3-r
  function automatic logic [2:0] pdest(input logic [2:0] op, input logic [2:0] r);
    return (op == 3'd2) ? r : 3'(3 - r);
  endfunction
  function automatic logic [WW-1:0] pword(input logic [2:0] op, input logic [2:0] r);
    return {op, 3'd0, r, 3'(3 - r)};
  endfunction
  function automatic logic [1:0] exp_sel(input bit need, input logic [2:0] r,
      input logic [2:0] mo, mr, wo, wr, to, tr);
    if (!need) return 2'd0;
    if (writes(mo) && pdest(mo, mr) == r) return 2'd1;
    if (writes(wo) && pdest(wo, wr) == r) return 2'd2;
    if (writes(to) && pdest(to, tr) == r) return 2'd3;
    return 2'd0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d (dec=%h exe=%h mem=%h wb=%h ret=%h t=%0b)",
               req, act, exp, dec_word, exe_word, mem_word, wb_word, ret_word, br_taken);
    end
  endtask

  initial begin
    dec_word = NOP_W; exe_word = NOP_W; mem_word = NOP_W;
    wb_word = NOP_W; ret_word = NOP_W; br_taken = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R10: idle pipeline gives all-zero control
    @(negedge clk); #1;
    vecs++;
    chk("R10 idle", {fwd_a, fwd_b, hold_front, bubble_exe, flush_dec, flush_exe, flush_mem}, 0);

    // Forwarding sweep: R1 producer fields, R2 operand use, R3/R4 selects, R5 priority
    for (int eo = 0; eo < 8; eo++)
      for (int ea = 1; ea <= 2; ea++)
        for (int eb = 1; eb <= 2; eb++)
          for (int mo = 0; mo < 8; mo++)
            for (int mr = 1; mr <= 2; mr++)
              for (int wi = 0; wi < 4; wi++)
                for (int wr = 1; wr <= 2; wr++)
                  for (int ti = 0; ti < 4; ti++)
                    for (int tr = 1; tr <= 2; tr++) begin
                      logic [2:0] wo, to;
                      wo = (wi == 3) ? 3'd7 : 3'(wi);
                      to = (ti == 3) ? 3'd3 : 3'(ti);
                      @(negedge clk);
                      dec_word = NOP_W;
                      exe_word = {3'(eo), 3'(ea), 3'(eb), 3'd0};
                      mem_word = pword(3'(mo), 3'(mr));
                      wb_word  = pword(wo, 3'(wr));
                      ret_word = pword(to, 3'(tr));
                      br_taken = 1'b0;
                      #1;
                      vecs++;
                      chk("R3 fwd_a", fwd_a, exp_sel(reads_a(3'(eo)), 3'(ea), 3'(mo), 3'(mr), wo, 3'(wr), to, 3'(tr)));
                      chk("R4 fwd_b", fwd_b, exp_sel(reads_b(3'(eo)), 3'(eb), 3'(mo), 3'(mr), wo, 3'(wr), to, 3'(tr)));
                      chk("R8 no flush untaken", flush_mem, 0);
                      chk("R7 no hold on noop decode", hold_front, 0);
                    end

    // Hold/squash sweep: R6 load-use, R7 unread fields, R8 squash, R9 priority
    for (int dop = 0; dop < 8; dop++)
      for (int da = 1; da <= 2; da++)
        for (int db = 1; db <= 2; db++)
          for (int eo = 0; eo < 8; eo++)
            for (int er = 1; er <= 2; er++)
              for (int mo = 0; mo < 8; mo++)
                for (int t = 0; t < 2; t++) begin
                  bit lu, sq;
                  @(negedge clk);
                  dec_word = {3'(dop), 3'(da), 3'(db), 3'(3 - da)};
                  exe_word = pword(3'(eo), 3'(er));
                  mem_word = {3'(mo), 3'd1, 3'd2, 3'd3};
                  wb_word  = NOP_W;
                  ret_word = NOP_W;
                  br_taken = 1'(t);
                  #1;
                  lu = (eo == 2) && ((reads_a(3'(dop)) && da == er) || (reads_b(3'(dop)) && db == er));
                  sq = (mo == 4) && (t == 1);
                  vecs++;
                  chk("R6 hold", hold_front, int'(lu && !sq));
                  chk("R9 bubble", bubble_exe, int'(lu && !sq));
                  chk("R8 flush_dec", flush_dec, int'(sq));
                  chk("R8 flush_exe", flush_exe, int'(sq));
                  chk("R8 flush_mem", flush_mem, int'(sq));
                end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule